// File: doc/BRIEF.md
# Serial-Bus Register-Pointer Slave

This block is a slave on a two-wire serial management bus. It gives a host access to a small register file that sits beside it. Both bus lines are sampled into the system clock domain through two flops each. From the sampled lines the block recognises START and STOP conditions and decodes nine-clock byte frames. It answers to one fixed 7-bit device address. SDA is open-drain: the block never drives a high level. It only asserts an output enable, and while that enable is set the pad pulls the line low.

Every access goes through a pointer register that keeps its value across transactions. In a write transaction, the first byte after the address selects the target register by loading the pointer. A second byte, if one is sent, is stored at that register. A read transaction returns one byte, taken from the register the pointer currently holds. A host that already knows the pointer value can therefore read with no write beforehand.

If SCL stays low longer than a programmable number of system-clock cycles, the block abandons the current transaction. This protects the bus from a stalled master, and a configuration pin turns the protection off. The register-file port has no handshake and no back-pressure. Write data arrives as a single-cycle strobe. Read data must be valid combinationally for whatever address the block presents, and the block samples it once, at the start of the read byte.

Top module: `smb_ptr_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal DEV_ADDR (default 7'h2E, giving 8'h5C for write and 8'h5D for read). For any other address it never asserts sda_oe before the next START.
- R2: A frame is eight data bits, MSB first, sampled on rising SCL, then a ninth clock. The slave holds SDA low through that ninth clock for a matching address and for every byte written to it.
- R3: SDA rising while SCL is high (STOP) returns the slave to idle with SDA released. SDA falling while SCL is high (START) begins address matching afresh from any state.
- R4: In a write transaction, the first byte after the address loads the pointer, and reg_addr always shows the pointer. After reset the pointer is 8'h00.
- R5: A second write byte produces exactly one single-cycle reg_we pulse, with reg_addr equal to the pointer and reg_wdata equal to the byte. A write that carries only the pointer byte produces no pulse.
- R6: Write bytes after the second are acknowledged but produce no strobe, and the pointer does not advance.
- R7: A read transaction (R/W = 1) shifts out reg_rdata for the current pointer, MSB first, with no preceding pointer write needed. After the eighth bit SDA is released and stays released until START or STOP.
- R8: A repeated START inside a transaction keeps the pointer, so a pointer write followed by a repeated START and a read returns that register.
- R9: When SCL is seen low for TMO_CYCLES consecutive system clocks with tmo_disable low, the transaction is abandoned. SDA is released and no byte is acknowledged before the next START.
- R10: While tmo_disable is high, a stall on SCL of any length leaves the transaction and the SDA drive unchanged.
- R11: Out of reset, sda_oe and reg_we are low and reg_addr is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pull SDA low when 1, release when 0 |
| tmo_disable | input | 1 | 1 turns off the SCL-low timeout |
| reg_addr | output | 8 | Register-file address (the pointer) |
| reg_wdata | output | 8 | Register-file write data |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 8 | Register-file read data for reg_addr |

## Verification
On every cycle the assertions check several rules. The write strobe never lasts longer than one cycle. SDA is driven only in an acknowledge slot or a read byte. A STOP, a START or a timeout leaves the data line released in the cycle that follows. The pointer moves only when the first write byte commits, and the stall counter clears whenever the clock line is high. Only the bench's bus scenarios can show the rest: which of all 128 addresses get an acknowledge, that stored and returned values match a model, that extra write bytes are ignored, that the pointer survives a repeated START, and that a stall is abandoned or kept depending on the disable pin.

// File: rtl/smb_ptr_pkg.sv
package smb_ptr_pkg;
  localparam int BYTE_W = 8;
  localparam int BITC_W = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_ADDR,
    LK_AACK,
    LK_WBYTE,
    LK_WACK,
    LK_RBYTE
  } link_st_t;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign scl_s    = scl_ff[1];
  assign sda_s    = sda_ff[1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_o  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_stall_timer.sv
module smb_stall_timer #(
  parameter int TMO_CYCLES = 5000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic dis,
  output logic hit
);
  localparam int CW = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT   = CW'(TMO_CYCLES);
  localparam logic [CW-1:0] LAST_LO = CW'(TMO_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (scl_s || dis)   cnt <= '0;
    else if (cnt != LIMIT)   cnt <= cnt + 1'b1;
  end

  assign hit = !scl_s && !dis && (cnt == LAST_LO);

  assert_tmo_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    scl_s |=> (cnt == '0))
    else $error("stall counter not cleared by high SCL");

  assert_tmo_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit)
    else $error("timeout fired twice in one stall");
endmodule

// File: rtl/smb_frame_engine.sv
module smb_frame_engine
  import smb_ptr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              tmo_i,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] ptr,
  output logic [BYTE_W-1:0] wdata,
  output logic              we
);
  localparam logic [BITC_W-1:0] FULL = BITC_W'(BYTE_W);

  link_st_t          st;
  logic [BITC_W-1:0] cnt;
  logic [BYTE_W-1:0] sh, tx;
  logic [1:0]        idx;
  logic              rd_mode;
  logic              commit_ptr;

  assign commit_ptr = (st == LK_WBYTE) && scl_fall && (cnt == FULL) &&
                      (idx == 2'd0) && !tmo_i && !start_i && !stop_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= LK_IDLE;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      idx     <= '0;
      rd_mode <= 1'b0;
      sda_oe  <= 1'b0;
      ptr     <= '0;
      wdata   <= '0;
      we      <= 1'b0;
    end else begin
      we <= 1'b0;
      if (tmo_i) begin
        st     <= LK_IDLE;
        sda_oe <= 1'b0;
      end else if (start_i) begin
        st     <= LK_ADDR;
        cnt    <= '0;
        idx    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_i) begin
        st     <= LK_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          LK_ADDR, LK_WBYTE: begin
            if (scl_rise && cnt < FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (st == LK_ADDR) begin
                if (sh[BYTE_W-1:1] == DEV_ADDR) begin
                  sda_oe  <= 1'b1;
                  rd_mode <= sh[0];
                  st      <= LK_AACK;
                end else begin
                  st <= LK_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                st     <= LK_WACK;
                if (idx == 2'd0) begin
                  ptr <= sh;
                end else if (idx == 2'd1) begin
                  we    <= 1'b1;
                  wdata <= sh;
                end
                if (idx != 2'd2) idx <= idx + 2'd1;
              end
            end
          end
          LK_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rd_mode) begin
                tx     <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                st     <= LK_RBYTE;
              end else begin
                sda_oe <= 1'b0;
                st     <= LK_WBYTE;
              end
            end
          end
          LK_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              st     <= LK_WBYTE;
            end
          end
          LK_RBYTE: begin
            if (scl_rise && cnt < FULL) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt != '0) begin
              if (cnt == FULL) begin
                sda_oe <= 1'b0;
                st     <= LK_IDLE;
              end else begin
                tx     <= {tx[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx[BYTE_W-2];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_we_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we)
    else $error("write strobe longer than one cycle");

  assert_oe_ctx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st == LK_AACK || st == LK_WACK || st == LK_RBYTE))
    else $error("SDA driven outside an ack slot or read byte");

  assert_stop_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !tmo_i && !start_i) |=> (!sda_oe && st == LK_IDLE))
    else $error("STOP did not release the bus");

  assert_start_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !tmo_i) |=> (!sda_oe && st == LK_ADDR))
    else $error("START did not restart address matching");

  assert_tmo_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_i |=> (!sda_oe && st == LK_IDLE))
    else $error("timeout did not release the bus");

  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_ptr |=> $stable(ptr))
    else $error("pointer changed outside first write byte");
endmodule

// File: rtl/smb_ptr_slave.sv
module smb_ptr_slave
  import smb_ptr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h2E,
  parameter int         TMO_CYCLES = 5000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              tmo_disable,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c, tmo_hit;

  smb_line_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_o  (start_c),
    .stop_o   (stop_c)
  );

  smb_stall_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_s (scl_s),
    .dis   (tmo_disable),
    .hit   (tmo_hit)
  );

  smb_frame_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_c),
    .stop_i   (stop_c),
    .tmo_i    (tmo_hit),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_s    (sda_s),
    .rd_data  (reg_rdata),
    .sda_oe   (sda_oe),
    .ptr      (reg_addr),
    .wdata    (reg_wdata),
    .we       (reg_we)
  );
endmodule

// File: tb/smb_ptr_slave_tb.sv
module smb_ptr_slave_tb;
  localparam int Q   = 6;
  localparam int TMO = 400;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       tmo_disable = 1'b0;
  logic       sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int         checks = 0, errors = 0, we_cnt = 0, cyc = 0;
  logic [7:0] last_a, last_d;
  logic       oe_seen = 1'b0;
  logic       done = 1'b0;
  wire        sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  smb_ptr_slave #(.DEV_ADDR(7'h2E), .TMO_CYCLES(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .tmo_disable(tmo_disable), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata));

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
      last_a <= reg_addr;
      last_d <= reg_wdata;
    end
  end

  always @(negedge clk) if (sda_oe) oe_seen = 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog (all requirements): act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
    sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q);
    sda_m = 1'b1; w(2*Q);
  endtask

  task automatic wbit(input logic b);
    sda_m = b; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); b = sda_line;
    w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(ack);
  endtask

  task automatic rbyte(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      rbit(b);
      d[i] = b;
    end
    wbit(1'b1);
  endtask

  initial begin
    logic       ack, a1, a2, a3;
    logic [7:0] rd;
    int         wc;
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 8'(i * 3 + 1);
      exp_mem[i] = 8'(i * 3 + 1);
    end
    w(4);
    // R11: state out of reset
    chk(sda_oe == 1'b0 && reg_we == 1'b0 && reg_addr == 8'h00, "R11",
        {sda_oe, reg_we, reg_addr}, 0);
    rst_n = 1'b1;
    w(4);

    // R1: sweep every 7-bit address, write direction
    for (int a = 0; a < 128; a++) begin
      bus_start();
      oe_seen = 1'b0;
      wbyte({7'(a), 1'b0}, ack);
      bus_stop();
      if (a == 'h2E) chk(ack == 1'b0, "R1 match ack", ack, 0);
      else chk(ack == 1'b1 && !oe_seen, "R1 no drive", {oe_seen, ack}, 1);
    end

    // R4 R5 R6 R7 R8: pointer and data sweep
    for (int k = 0; k < 16; k++) begin
      logic [7:0] p, d, q;
      p = 8'(k * 17 + 5);
      d = 8'((p ^ 8'hA5) + k);
      q = p + 8'd1;

      wc = we_cnt;
      bus_start(); wbyte(8'h5C, a1); wbyte(p, a2); wbyte(d, a3); bus_stop();
      exp_mem[p] = d;
      chk({a1, a2, a3} == 3'b000, "R2 ack each byte", {a1, a2, a3}, 0);
      chk(we_cnt == wc + 1 && last_a == p && last_d == d, "R5 strobe",
          {last_a, last_d}, {p, d});
      chk(reg_addr == p, "R4 pointer", reg_addr, p);

      bus_start(); wbyte(8'h5D, a1); rbyte(rd);
      chk(sda_oe == 1'b0, "R7 release after read", sda_oe, 0);
      bus_stop();
      chk(a1 == 1'b0 && rd == exp_mem[p], "R7 read at pointer", rd, exp_mem[p]);

      wc = we_cnt;
      bus_start(); wbyte(8'h5C, a1); wbyte(p, a2); wbyte(~d, a3);
      wbyte(d + 8'd1, ack); bus_stop();
      exp_mem[p] = ~d;
      chk(ack == 1'b0 && we_cnt == wc + 1 && last_d == ~d && reg_addr == p,
          "R6 extra byte ignored", {ack, last_d, reg_addr}, {1'b0, ~d, p});

      wc = we_cnt;
      bus_start(); wbyte(8'h5C, a1); wbyte(q, a2);
      chk(we_cnt == wc, "R5 pointer-only no strobe", we_cnt - wc, 0);
      bus_start(); wbyte(8'h5D, a3); rbyte(rd); bus_stop();
      chk(rd == exp_mem[q] && we_cnt == wc, "R8 repeated START keeps pointer",
          rd, exp_mem[q]);
    end

    // R9: stall during the address ack slot
    bus_start();
    for (int i = 7; i >= 0; i--) wbit(logic'((8'h5C >> i) & 1));
    w(TMO + 200);
    chk(sda_oe == 1'b0, "R9 stall releases", sda_oe, 0);
    rbit(ack);
    oe_seen = 1'b0;
    wbyte(8'h5C, a1);
    bus_stop();
    chk(ack == 1'b1 && a1 == 1'b1 && !oe_seen, "R9 no ack until START",
        {oe_seen, ack, a1}, 3'b011);

    // R10: same stall with the timeout disabled
    tmo_disable = 1'b1;
    bus_start();
    for (int i = 7; i >= 0; i--) wbit(logic'((8'h5C >> i) & 1));
    w(TMO + 200);
    chk(sda_oe == 1'b1, "R10 stall kept", sda_oe, 1);
    rbit(ack);
    wbyte(8'h33, a1);
    bus_stop();
    chk(ack == 1'b0 && a1 == 1'b0 && reg_addr == 8'h33, "R10 transaction continues",
        {ack, a1, reg_addr}, 8'h33);
    tmo_disable = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule